// File: doc/BRIEF.md
# Receive Error-Filtering Byte Ring

This block sits between a serial receiver's byte output and whatever consumes the received data. Each byte arrives with a valid strobe and four line-error flags: overrun, parity, framing and break. A byte with none of these flags set is written into a circular store. A byte with any flag set is thrown away. The parity, framing and overrun flags each advance their own saturating counter. A break-flagged byte is discarded but is not counted anywhere.

The store keeps one slot unused, so it has `DEPTH + 1` physical slots and holds at most `DEPTH` bytes. It counts as full when advancing the write index would make it equal to the read index. A clean byte that arrives while the store is full is lost without any trace.

The consumer pulls data by asking for up to N bytes. The block answers with the number it will actually deliver, which is the smaller of N and the current fill level. It then streams that many bytes out, one per cycle. After each burst of arrivals ends, a single notification pulse tells the consumer that new input has been handled.

Top module: `rx_filter_ring`

## Requirements
- R1: Clean bytes (valid with all four error flags low) are delivered on the read port in arrival order, with the byte value unchanged.
- R2: A byte that arrives with any of the overrun, parity, framing or break flags high is not stored, so a later read does not count it.
- R3: On each valid byte, every one of the parity, framing and overrun flags that is high adds one to its own counter. When several flags are high together, each of their counters advances.
- R4: A byte that carries only the break flag is dropped and leaves all three counters unchanged.
- R5: The store holds at most `DEPTH` bytes. A clean byte that arrives while it is full is discarded and no counter changes.
- R6: A request (`rdReq` high for one cycle with length `rdLen`) that is accepted produces `rdAck` high for exactly the next cycle, with `rdGrant` equal to min(`rdLen`, fill level at the request edge). The granted bytes then appear on `rdValid`/`rdData` in the following `rdGrant` consecutive cycles. A grant of zero sends no bytes.
- R7: A request made while `rdBusy` is high is ignored: it produces no `rdAck` and delivers no extra bytes.
- R8: The read and write indices wrap modulo `DEPTH + 1`. Data order and fill level stay correct across any number of wraps.
- R9: When a cycle with `inValid` low follows one or more cycles with `inValid` high, `notify` is high for exactly one cycle, the cycle after that first idle cycle. The burst may contain clean or flagged bytes.
- R10: Each error counter stops at its all-ones value and stays there.
- R11: A high `clear` for one cycle zeroes all three counters, empties the store, and stops any read stream in progress.
- R12: A byte stored and a byte read out in the same cycle are both honoured, and the fill level moves by the net change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of counters, indices and read state |
| inValid | input | 1 | A received byte is present this cycle |
| inData | input | DATA_W | Received byte |
| inOverrun | input | 1 | Overrun flag for this byte |
| inParity | input | 1 | Parity flag for this byte |
| inFraming | input | 1 | Framing flag for this byte |
| inBreak | input | 1 | Break flag for this byte |
| rdReq | input | 1 | Read request strobe |
| rdLen | input | LEN_W | Number of bytes requested |
| rdAck | output | 1 | Request accepted, grant valid |
| rdGrant | output | LEN_W | Number of bytes that will be delivered |
| rdBusy | output | 1 | Stream in progress; new requests are ignored |
| rdValid | output | 1 | `rdData` carries a delivered byte |
| rdData | output | DATA_W | Delivered byte |
| notify | output | 1 | One-cycle pulse after a burst of arrivals ends |
| parityCount | output | CNT_W | Saturating parity error count |
| framingCount | output | CNT_W | Saturating framing error count |
| overrunCount | output | CNT_W | Saturating overrun error count |

## Verification
The bench runs a small store (seven usable slots) through every fill level with request lengths both below and above the fill level. This exposes a grant computed from the wrong wrap formula, or one that is not clamped, because the grant count or the delivered bytes would come out wrong. It drives all sixteen error-flag combinations twice, which catches a design that counts break, that stores a flagged byte, or whose 3-bit counters wrap to zero instead of holding. It also fills the store past capacity, writes during a read stream, issues a request while a stream is still running, and clears the block in the middle of a stream. A block with a missing spare slot, a lost concurrent write, a second acknowledge, or a stream that survives the clear would each fail its own check.

// File: rtl/rx_filter_ring_pkg.sv
package rx_filter_ring_pkg;

  // Strobes from the control module to the datapath, one set per cycle.
  typedef struct packed {
    logic store;       // write inData at the write index
    logic pop;         // present the byte at the read index, advance it
    logic incParity;   // bump parity counter
    logic incFraming;  // bump framing counter
    logic incOverrun;  // bump overrun counter
    logic clear;       // zero counters and indices
  } ringStrobe_t;

endpackage

// File: rtl/rx_filter_ring_dp.sv
module rx_filter_ring_dp
  import rx_filter_ring_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 512,
  parameter int CNT_W  = 32,
  localparam int SLOTS = DEPTH + 1,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ringStrobe_t       strobe,
  input  logic [DATA_W-1:0] inData,
  output logic              full,
  output logic [IDX_W-1:0]  avail,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [CNT_W-1:0]  parityCount,
  output logic [CNT_W-1:0]  framingCount,
  output logic [CNT_W-1:0]  overrunCount
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOTS - 1);
  localparam logic [IDX_W-1:0] WRAP_ADD = IDX_W'(SLOTS);

  logic [DATA_W-1:0] mem [SLOTS];
  logic [IDX_W-1:0]  wrIdx, rdIdx, wrNext, rdNext;

  assign wrNext = (wrIdx == LAST_IDX) ? '0 : wrIdx + 1'b1;
  assign rdNext = (rdIdx == LAST_IDX) ? '0 : rdIdx + 1'b1;
  // Spare slot: full when the next write position would meet the read index.
  assign full   = (wrNext == rdIdx);
  // The difference is taken modulo 2^IDX_W; adding SLOTS undoes the ring wrap.
  assign avail  = (wrIdx >= rdIdx) ? (wrIdx - rdIdx) : (wrIdx - rdIdx + WRAP_ADD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrIdx <= '0;
      rdIdx <= '0;
    end else if (strobe.clear) begin
      wrIdx <= '0;
      rdIdx <= '0;
    end else begin
      if (strobe.store) wrIdx <= wrNext;
      if (strobe.pop)   rdIdx <= rdNext;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.store) mem[wrIdx] <= inData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strobe.pop;
      if (strobe.pop) rdData <= mem[rdIdx];
    end
  end

  // Three identical saturating counters: 0 parity, 1 framing, 2 overrun.
  logic [2:0] incVec;
  assign incVec = {strobe.incOverrun, strobe.incFraming, strobe.incParity};

  for (genvar g = 0; g < 3; g++) begin : gCnt
    logic [CNT_W-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         cnt <= '0;
      else if (strobe.clear)              cnt <= '0;
      else if (incVec[g] && (cnt != '1))  cnt <= cnt + 1'b1;
    end

    // R10
    count_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '1) && !strobe.clear |=> (cnt == '1));
  end

  assign parityCount  = gCnt[0].cnt;
  assign framingCount = gCnt[1].cnt;
  assign overrunCount = gCnt[2].cnt;

  logic [IDX_W:0] occNext;
  assign occNext = {1'b0, avail} + {{IDX_W{1'b0}}, strobe.store}
                 - {{IDX_W{1'b0}}, strobe.pop};

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.store |-> (avail < IDX_W'(DEPTH)));

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.pop |-> (avail != '0));

  // R12
  occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.clear |=> ({1'b0, avail} == $past(occNext)));

  // R11
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.clear |=> (avail == '0) && !full);

endmodule

// File: rtl/rx_filter_ring_ctrl.sv
module rx_filter_ring_ctrl
  import rx_filter_ring_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int IDX_W = 10,
  localparam int MW   = (LEN_W > IDX_W) ? LEN_W : IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             inValid,
  input  logic             inOverrun,
  input  logic             inParity,
  input  logic             inFraming,
  input  logic             inBreak,
  input  logic             full,
  input  logic [IDX_W-1:0] avail,
  input  logic             rdReq,
  input  logic [LEN_W-1:0] rdLen,
  output ringStrobe_t      strobe,
  output logic             rdAck,
  output logic [LEN_W-1:0] rdGrant,
  output logic             rdBusy,
  output logic             notify
);

  logic             anyErr, accept, pending;
  logic [LEN_W-1:0] remaining, grant;
  logic [MW-1:0]    lenW, availW, grantW;

  assign anyErr = inOverrun | inParity | inFraming | inBreak;
  assign rdBusy = (remaining != '0);
  assign accept = rdReq && !rdBusy && !clear;

  assign lenW   = MW'(rdLen);
  assign availW = MW'(avail);
  assign grantW = (lenW < availW) ? lenW : availW;
  assign grant  = LEN_W'(grantW);

  always_comb begin
    strobe            = '0;
    strobe.clear      = clear;
    strobe.store      = inValid && !anyErr && !full && !clear;
    strobe.incParity  = inValid && inParity && !clear;
    strobe.incFraming = inValid && inFraming && !clear;
    strobe.incOverrun = inValid && inOverrun && !clear;
    strobe.pop        = rdBusy && !clear;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remaining <= '0;
      rdAck     <= 1'b0;
      rdGrant   <= '0;
      pending   <= 1'b0;
      notify    <= 1'b0;
    end else if (clear) begin
      remaining <= '0;
      rdAck     <= 1'b0;
      pending   <= 1'b0;
      notify    <= 1'b0;
    end else begin
      rdAck <= accept;
      if (accept) begin
        rdGrant   <= grant;
        remaining <= grant;
      end else if (rdBusy) begin
        remaining <= remaining - 1'b1;
      end
      notify  <= pending && !inValid;
      pending <= inValid;
    end
  end

  // R9
  notify_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    notify |=> !notify);

  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdBusy |=> !rdAck);

  // R6
  grant_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdAck |-> (rdGrant <= $past(rdLen)));

endmodule

// File: rtl/rx_filter_ring.sv
module rx_filter_ring
  import rx_filter_ring_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 512,
  parameter int CNT_W  = 32,
  parameter int LEN_W  = 16,
  localparam int IDX_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  input  logic              inOverrun,
  input  logic              inParity,
  input  logic              inFraming,
  input  logic              inBreak,
  input  logic              rdReq,
  input  logic [LEN_W-1:0]  rdLen,
  output logic              rdAck,
  output logic [LEN_W-1:0]  rdGrant,
  output logic              rdBusy,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              notify,
  output logic [CNT_W-1:0]  parityCount,
  output logic [CNT_W-1:0]  framingCount,
  output logic [CNT_W-1:0]  overrunCount
);

  ringStrobe_t      strobe;
  logic             full;
  logic [IDX_W-1:0] avail;

  rx_filter_ring_ctrl #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .inValid(inValid), .inOverrun(inOverrun), .inParity(inParity),
    .inFraming(inFraming), .inBreak(inBreak),
    .full(full), .avail(avail),
    .rdReq(rdReq), .rdLen(rdLen),
    .strobe(strobe), .rdAck(rdAck), .rdGrant(rdGrant),
    .rdBusy(rdBusy), .notify(notify)
  );

  rx_filter_ring_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .inData(inData),
    .full(full), .avail(avail),
    .rdValid(rdValid), .rdData(rdData),
    .parityCount(parityCount), .framingCount(framingCount),
    .overrunCount(overrunCount)
  );

endmodule

// File: tb/rx_filter_ring_bench.sv
module rx_filter_ring_bench;

  localparam int DATA_W = 8;
  localparam int DEPTH  = 7;
  localparam int CNT_W  = 3;
  localparam int LEN_W  = 5;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0;
  logic inValid = 1'b0;
  logic [DATA_W-1:0] inData = '0;
  logic inOverrun = 1'b0, inParity = 1'b0, inFraming = 1'b0, inBreak = 1'b0;
  logic rdReq = 1'b0;
  logic [LEN_W-1:0] rdLen = '0;
  logic rdAck, rdBusy, rdValid, notify;
  logic [LEN_W-1:0] rdGrant;
  logic [DATA_W-1:0] rdData;
  logic [CNT_W-1:0] parityCount, framingCount, overrunCount;

  always #4 clk = ~clk;

  rx_filter_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .LEN_W(LEN_W))
  u_rx_filter_ring (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .inValid(inValid), .inData(inData), .inOverrun(inOverrun),
    .inParity(inParity), .inFraming(inFraming), .inBreak(inBreak),
    .rdReq(rdReq), .rdLen(rdLen), .rdAck(rdAck), .rdGrant(rdGrant),
    .rdBusy(rdBusy), .rdValid(rdValid), .rdData(rdData), .notify(notify),
    .parityCount(parityCount), .framingCount(framingCount),
    .overrunCount(overrunCount)
  );

  int vecs = 0;
  int errs = 0;
  bit finished = 0;
  logic [DATA_W-1:0] model[$];
  int mPar = 0, mFrm = 0, mOvr = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chkCnt(input string req);
    chk(parityCount == CNT_W'(mPar), req, int'(parityCount), mPar);
    chk(framingCount == CNT_W'(mFrm), req, int'(framingCount), mFrm);
    chk(overrunCount == CNT_W'(mOvr), req, int'(overrunCount), mOvr);
  endtask

  task automatic pushByte(input logic [7:0] d, input logic o, input logic p,
                          input logic f, input logic b);
    @(negedge clk);
    inValid = 1'b1; inData = d;
    inOverrun = o; inParity = p; inFraming = f; inBreak = b;
    if (p && mPar < CMAX) mPar++;
    if (f && mFrm < CMAX) mFrm++;
    if (o && mOvr < CMAX) mOvr++;
    if (!(o | p | f | b) && model.size() < DEPTH) model.push_back(d);
  endtask

  // Ends a burst and checks the one-cycle notification (R9).
  task automatic endBurst();
    @(negedge clk);
    inValid = 1'b0; inOverrun = 0; inParity = 0; inFraming = 0; inBreak = 0;
    chk(notify == 1'b0, "R9 early", int'(notify), 0);
    @(negedge clk);
    chk(notify == 1'b1, "R9 pulse", int'(notify), 1);
    @(negedge clk);
    chk(notify == 1'b0, "R9 single", int'(notify), 0);
  endtask

  task automatic readN(input int n);
    int expG;
    @(negedge clk);
    rdReq = 1'b1; rdLen = LEN_W'(n);
    expG = (n < model.size()) ? n : model.size();
    @(negedge clk);
    rdReq = 1'b0;
    chk(rdAck == 1'b1, "R6 ack", int'(rdAck), 1);
    chk(int'(rdGrant) == expG, "R6 grant", int'(rdGrant), expG);
    for (int k = 0; k < expG; k++) begin
      logic [7:0] e;
      @(negedge clk);
      e = model.pop_front();
      chk(rdValid == 1'b1, "R1 valid", int'(rdValid), 1);
      chk(rdData == e, "R1 data", int'(rdData), int'(e));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    chk(rdBusy == 0 && rdValid == 0 && notify == 0 && rdAck == 0, "R11 reset",
        int'({rdBusy, rdValid, notify, rdAck}), 0);
    chkCnt("R11 reset");

    // R1 R6 R8: every fill level against request lengths below and above it
    for (int f = 0; f <= DEPTH; f++) begin
      for (int n = 0; n <= DEPTH + 2; n++) begin
        for (int i = 0; i < f; i++)
          pushByte(8'((f * 16 + i * 7 + n) & 8'hFF), 0, 0, 0, 0);
        if (f > 0) endBurst();
        readN(n);
        readN(DEPTH + 2);
      end
    end

    // R5: overfill by two; extra clean bytes vanish, counters untouched
    for (int i = 0; i < DEPTH + 2; i++) pushByte(8'(8'h40 + i), 0, 0, 0, 0);
    endBurst();
    chkCnt("R5 counters");
    readN(DEPTH + 2);

    // R2 R3 R4 R10: all sixteen flag combinations, twice to reach saturation
    for (int rep = 0; rep < 2; rep++) begin
      for (int fl = 0; fl < 16; fl++) begin
        pushByte(8'h5A, fl[0], fl[1], fl[2], fl[3]);
        endBurst();
        if (fl == 8)      chkCnt("R4 break only");
        else if (rep == 1) chkCnt("R10 saturation");
        else              chkCnt("R3 counters");
        readN(1); // grant 1 only when fl == 0 (R2)
      end
    end
    chk(parityCount == CNT_W'(CMAX), "R10 held", int'(parityCount), CMAX);

    // R7: request during an active stream is ignored
    for (int i = 0; i < 4; i++) pushByte(8'(8'hC0 + i), 0, 0, 0, 0);
    endBurst();
    @(negedge clk);
    rdReq = 1; rdLen = 2;
    @(negedge clk);
    rdReq = 1; rdLen = 3;
    chk(rdGrant == 2, "R7 first grant", int'(rdGrant), 2);
    @(negedge clk);
    rdReq = 0;
    chk(rdAck == 0, "R7 no second ack", int'(rdAck), 0);
    chk(rdData == model.pop_front(), "R7 data", int'(rdData), 8'hC0);
    @(negedge clk);
    chk(rdData == model.pop_front(), "R7 data", int'(rdData), 8'hC1);
    @(negedge clk);
    chk(rdValid == 0 && rdAck == 0, "R7 stream ends", int'({rdValid, rdAck}), 0);
    readN(DEPTH);

    // R12: writes land while a stream is draining
    for (int i = 0; i < 4; i++) pushByte(8'(8'h70 + i), 0, 0, 0, 0);
    endBurst();
    fork
      readN(4);
      begin
        @(negedge clk); @(negedge clk);
        for (int i = 0; i < 3; i++) pushByte(8'(8'h90 + i), 0, 0, 0, 0);
        @(negedge clk);
        inValid = 1'b0;
      end
    join
    chk(model.size() == 3, "R12 model", model.size(), 3);
    readN(DEPTH);

    // R11: clear wipes counters, store and a running stream
    for (int i = 0; i < 5; i++) pushByte(8'(8'h20 + i), 0, 0, 0, 0);
    pushByte(8'h33, 1, 1, 1, 0);
    endBurst();
    @(negedge clk);
    rdReq = 1; rdLen = 5;
    @(negedge clk);
    rdReq = 0;
    @(negedge clk);
    clear = 1;
    @(negedge clk);
    clear = 0;
    model.delete();
    mPar = 0; mFrm = 0; mOvr = 0;
    chk(rdBusy == 0, "R11 stream stopped", int'(rdBusy), 0);
    chkCnt("R11 counters");
    @(negedge clk);
    chk(rdValid == 0, "R11 no data", int'(rdValid), 0);
    readN(5);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule